// File: doc/BRIEF.md
# Asynchronous Serial Receiver with Character Status FIFO

This block is the receive side of one asynchronous serial channel. Each rising edge of `clk_i` is one sample of the line. The line passes through a synchronizer, and a falling edge starts a start-bit check. The block then takes the programmed number of data bits, LSB first, and an optional parity bit. Last it checks one stop bit. A finished character goes into a three-entry FIFO together with its parity and framing flags.

The host reads the character at the head of the FIFO from `data_o` while `avail_o` is high. A one-cycle `rd_i` pulse removes it. The framing flag belongs to the character at the head. Parity and overrun errors are sticky: they stay set until the host pulses `err_reset_i`. A line held low for a whole character, stop position included, raises `break_o`. The frame being assembled forms a fourth holding stage behind the FIFO. The configuration inputs are assumed to be stable while a character is being received.

Top module: `async_rx_chan`

## Requirements
- R1: After reset, `avail_o`, `par_err_o`, `ovr_err_o`, `frm_err_o` and `break_o` are all 0.
- R2: The 2-bit `len_code_i` sets the number of data bits: 0 gives 5, 1 gives 7, 2 gives 6 and 3 gives 8. Data arrives LSB first. The character appears right-justified on `data_o`, and the bits above its length read 0.
- R3: The 2-bit `clk_mode_i` sets the samples per bit: 0 gives 1, 1 gives 16, 2 gives 32 and 3 gives 64. In the multiplied modes, a start bit counts only if the line is still low half a bit after the falling edge. A low pulse shorter than that stores nothing. Data bits are sampled at their centres.
- R4: When `par_en_i` is 1, a parity bit follows the data bits. `par_even_i` selects the type: 0 is odd and 1 is even. The parity bit is not stored. If the parity is wrong, `par_err_o` is set when that character reaches the head of the FIFO.
- R5: If the stop bit is sampled low, the character is stored with a framing flag. `frm_err_o` is high exactly while that character is at the head of the FIFO.
- R6: The FIFO holds three characters in arrival order. `avail_o` is high whenever the FIFO is not empty. A `rd_i` pulse removes the head. A `rd_i` pulse while the FIFO is empty has no effect.
- R7: If a character completes while three are stored and there is no read in that cycle, the new character replaces the third entry. The first two entries stay as they are, and `ovr_err_o` is set.
- R8: A frame whose data, parity and stop positions are all low sets `break_o`. It also stores the character 0 with the framing flag. `break_o` clears once the line is back high. No new start bit is accepted until the line has returned high. A framing error on nonzero data does not set `break_o`.
- R9: While `rx_en_i` is 0, line activity stores nothing, and characters already in the FIFO are kept.
- R10: `par_err_o` and `ovr_err_o` stay set until `err_reset_i` is pulsed, and that pulse clears both.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Sample clock, one line sample per edge |
| rst_ni | input | 1 | Active-low asynchronous reset |
| rx_i | input | 1 | Serial line, idle high |
| rx_en_i | input | 1 | Receiver enable |
| clk_mode_i | input | 2 | Samples per bit code |
| len_code_i | input | 2 | Data length code |
| par_en_i | input | 1 | Parity bit present |
| par_even_i | input | 1 | Parity type, 1 = even |
| rd_i | input | 1 | Pop the head character |
| err_reset_i | input | 1 | Clear sticky parity and overrun flags |
| data_o | output | 8 | Head character |
| avail_o | output | 1 | FIFO not empty |
| par_err_o | output | 1 | Sticky parity error |
| ovr_err_o | output | 1 | Sticky overrun error |
| frm_err_o | output | 1 | Framing error of the head character |
| break_o | output | 1 | Break condition on the line |

## Verification
The bench covers the non-monotonic length code in every clock mode. A wrong decode would return 6-bit data where 7 bits were expected, or leave stray high bits. A short low glitch in ×16 mode checks the half-bit confirmation: a receiver without it would store a spurious character, and the scoreboard would report it. Four characters with no reads check the overrun: a wrong FIFO would lose the head, shift the entries, or drop the newest character instead of replacing the third. A read on the empty FIFO just before this test catches a count that underflows. A held-low break and disabled-receiver traffic check that neither produces extra characters. The sticky flags are checked across the host reads and the error-reset pulse.

// File: rtl/rx_pkg.sv
package rx_pkg;
  localparam int CHAR_W = 8;
  localparam int CNT_W  = 6;

  // length code is not monotonic
  function automatic logic [3:0] char_len(input logic [1:0] code);
    case (code)
      2'd0:    return 4'd5;
      2'd1:    return 4'd7;
      2'd2:    return 4'd6;
      default: return 4'd8;
    endcase
  endfunction

  // samples per bit minus one
  function automatic logic [CNT_W-1:0] bit_last(input logic [1:0] mode);
    case (mode)
      2'd0:    return 6'd0;
      2'd1:    return 6'd15;
      2'd2:    return 6'd31;
      default: return 6'd63;
    endcase
  endfunction

  typedef enum logic [1:0] {ST_IDLE, ST_START, ST_BITS, ST_MARK} rx_state_e;

  typedef struct packed {
    logic [CHAR_W-1:0] data;
    logic              par_err;
    logic              frm_err;
  } rx_entry_t;
endpackage

// File: rtl/rx_sync.sv
module rx_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] sr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sr_q <= '1;
    else         sr_q <= {sr_q[STAGES-2:0], d_i};
  end

  assign q_o = sr_q[STAGES-1];
endmodule

// File: rtl/rx_framer.sv
module rx_framer
  import rx_pkg::*;
(
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        rx_s_i,
  input  logic        en_i,
  input  logic [1:0]  clk_mode_i,
  input  logic [1:0]  len_code_i,
  input  logic        par_en_i,
  input  logic        par_even_i,
  output logic        push_o,
  output rx_entry_t   entry_o,
  output logic        break_o
);
  rx_state_e         state_q;
  logic [CNT_W-1:0]  cnt_q;
  logic [3:0]        idx_q;
  logic [CHAR_W-1:0] shift_q;
  logic              par_acc_q;
  logic              zero_q;
  logic              brk_q;

  logic [CNT_W-1:0]  per;
  logic [CNT_W-1:0]  half;
  logic [3:0]        len;
  logic [3:0]        last_idx;

  assign per      = bit_last(clk_mode_i);
  assign half     = per >> 1;
  assign len      = char_len(len_code_i);
  assign last_idx = len + {3'd0, par_en_i};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q   <= ST_IDLE;
      cnt_q     <= '0;
      idx_q     <= '0;
      shift_q   <= '0;
      par_acc_q <= 1'b0;
      zero_q    <= 1'b1;
      brk_q     <= 1'b0;
      push_o    <= 1'b0;
      entry_o   <= '0;
    end else begin
      push_o <= 1'b0;
      if (rx_s_i) brk_q <= 1'b0;
      if (!en_i) begin
        state_q <= ST_IDLE;
      end else begin
        case (state_q)
          ST_IDLE: if (!rx_s_i) begin
            shift_q   <= '0;
            idx_q     <= '0;
            par_acc_q <= 1'b0;
            zero_q    <= 1'b1;
            if (per == '0) begin
              state_q <= ST_BITS;
              cnt_q   <= '0;
            end else begin
              state_q <= ST_START;
              cnt_q   <= half;
            end
          end
          ST_START: begin
            if (cnt_q != '0) cnt_q <= cnt_q - 1'b1;
            else if (rx_s_i) state_q <= ST_IDLE;   // glitch, not a start bit
            else begin
              state_q <= ST_BITS;
              cnt_q   <= per;
            end
          end
          ST_BITS: begin
            if (cnt_q != '0) begin
              cnt_q <= cnt_q - 1'b1;
            end else begin
              cnt_q <= per;
              if (idx_q == last_idx) begin
                push_o          <= 1'b1;
                entry_o.data    <= shift_q;
                entry_o.par_err <= par_en_i & (par_acc_q ^ ~par_even_i);
                entry_o.frm_err <= ~rx_s_i;
                if (!rx_s_i) begin
                  state_q <= ST_MARK;
                  if (zero_q) brk_q <= 1'b1;
                end else begin
                  state_q <= ST_IDLE;
                end
              end else begin
                if (idx_q < len) shift_q[idx_q[2:0]] <= rx_s_i;
                par_acc_q <= par_acc_q ^ rx_s_i;
                if (rx_s_i) zero_q <= 1'b0;
                idx_q <= idx_q + 1'b1;
              end
            end
          end
          default: if (rx_s_i) state_q <= ST_IDLE;
        endcase
      end
    end
  end

  assign break_o = brk_q;

  p_disabled_idle_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> (state_q == ST_IDLE));
  p_break_clear_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (break_o && rx_s_i) |=> !break_o);
  p_break_has_push_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(break_o) |-> (push_o && entry_o.frm_err && entry_o.data == '0));
endmodule

// File: rtl/rx_fifo.sv
module rx_fifo
  import rx_pkg::*;
#(
  parameter int DEPTH = 3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              push_i,
  input  rx_entry_t         wdata_i,
  input  logic              pop_i,
  output logic [CHAR_W-1:0] head_data_o,
  output logic              head_frm_o,
  output logic              avail_o,
  output logic              ovf_o,
  output logic              head_par_load_o
);
  localparam int CW = $clog2(DEPTH + 1);

  rx_entry_t       mem_q [DEPTH];
  logic [CW-1:0]   cnt_q;
  logic [CW-1:0]   widx;
  logic            pop_ok;
  logic            full;

  assign full   = (cnt_q == CW'(DEPTH));
  assign pop_ok = pop_i && (cnt_q != '0);
  assign ovf_o  = push_i && !pop_ok && full;

  always_comb begin
    if (pop_ok)    widx = cnt_q - 1'b1;
    else if (full) widx = CW'(DEPTH - 1);  // overwrite newest slot
    else           widx = cnt_q;
  end

  always_comb begin
    head_par_load_o = 1'b0;
    if (push_i && cnt_q == '0)                 head_par_load_o = wdata_i.par_err;
    else if (pop_ok && cnt_q >= CW'(2))        head_par_load_o = mem_q[1].par_err;
    else if (pop_ok && cnt_q == CW'(1) && push_i) head_par_load_o = wdata_i.par_err;
  end

  for (genvar i = 0; i < DEPTH; i++) begin : g_slot
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        mem_q[i] <= '0;
      end else if (push_i && widx == CW'(i)) begin
        mem_q[i] <= wdata_i;
      end else if (pop_ok) begin
        if (i < DEPTH - 1) mem_q[i] <= mem_q[(i < DEPTH - 1) ? i + 1 : i];
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cnt_q <= '0;
    else if (push_i && !pop_ok && !full) cnt_q <= cnt_q + 1'b1;
    else if (pop_ok && !push_i)          cnt_q <= cnt_q - 1'b1;
  end

  assign avail_o     = (cnt_q != '0);
  assign head_data_o = mem_q[0].data;
  assign head_frm_o  = mem_q[0].frm_err;

  p_no_overflow_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ovf_o |=> (cnt_q == CW'(DEPTH)));
  p_ovf_keeps_head_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ovf_o |=> $stable(mem_q[0]));
  p_push_avail_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    push_i |=> avail_o);
  p_empty_pop_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!avail_o && pop_i && !push_i) |=> !avail_o);
endmodule

// File: rtl/async_rx_chan.sv
module async_rx_chan
  import rx_pkg::*;
#(
  parameter int DEPTH       = 3,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              rx_i,
  input  logic              rx_en_i,
  input  logic [1:0]        clk_mode_i,
  input  logic [1:0]        len_code_i,
  input  logic              par_en_i,
  input  logic              par_even_i,
  input  logic              rd_i,
  input  logic              err_reset_i,
  output logic [CHAR_W-1:0] data_o,
  output logic              avail_o,
  output logic              par_err_o,
  output logic              ovr_err_o,
  output logic              frm_err_o,
  output logic              break_o
);
  logic      rx_s;
  logic      push;
  rx_entry_t entry;
  logic      head_frm;
  logic      ovf;
  logic      par_load;
  logic      par_q, ovr_q;

  rx_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk_i (clk_i), .rst_ni(rst_ni), .d_i(rx_i), .q_o(rx_s)
  );

  rx_framer u_framer (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .rx_s_i     (rx_s),
    .en_i       (rx_en_i),
    .clk_mode_i (clk_mode_i),
    .len_code_i (len_code_i),
    .par_en_i   (par_en_i),
    .par_even_i (par_even_i),
    .push_o     (push),
    .entry_o    (entry),
    .break_o    (break_o)
  );

  rx_fifo #(.DEPTH(DEPTH)) u_fifo (
    .clk_i           (clk_i),
    .rst_ni          (rst_ni),
    .push_i          (push),
    .wdata_i         (entry),
    .pop_i           (rd_i),
    .head_data_o     (data_o),
    .head_frm_o      (head_frm),
    .avail_o         (avail_o),
    .ovf_o           (ovf),
    .head_par_load_o (par_load)
  );

  // sticky flags: a new set wins over a clear in the same cycle
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      par_q <= 1'b0;
      ovr_q <= 1'b0;
    end else begin
      par_q <= (par_q & ~err_reset_i) | par_load;
      ovr_q <= (ovr_q & ~err_reset_i) | ovf;
    end
  end

  assign par_err_o = par_q;
  assign ovr_err_o = ovr_q;
  assign frm_err_o = avail_o & head_frm;

  p_ovr_sticky_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ovr_err_o && !err_reset_i) |=> ovr_err_o);
  p_par_sticky_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (par_err_o && !err_reset_i) |=> par_err_o);
  p_err_clear_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (err_reset_i && !ovf && !par_load) |=> (!ovr_err_o && !par_err_o));
  p_frm_needs_char_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    frm_err_o |-> avail_o);
endmodule

// File: tb/async_rx_chan_bench.sv
`timescale 1ns/1ps
module async_rx_chan_bench;
  typedef struct packed {
    logic [7:0]  d;
    logic        frm;
    logic [23:0] tag;
  } exp_t;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       rx = 1'b1;
  logic       rx_en = 1'b1;
  logic [1:0] mode = 2'd1;
  logic [1:0] len = 2'd3;
  logic       pe = 1'b0;
  logic       pev = 1'b0;
  logic       mon_rd = 1'b0;
  logic       tst_rd = 1'b0;
  logic       rd;
  logic       err_rst = 1'b0;
  logic [7:0] data;
  logic       avail, par_err, ovr_err, frm_err, brk;

  int   checks = 0;
  int   fails  = 0;
  bit   done   = 1'b0;
  bit   mon_en = 1'b1;
  exp_t q[$];

  assign rd = mon_rd | tst_rd;

  always #5 clk = ~clk;

  async_rx_chan u_async_rx_chan (
    .clk_i(clk), .rst_ni(rst_n), .rx_i(rx), .rx_en_i(rx_en),
    .clk_mode_i(mode), .len_code_i(len), .par_en_i(pe), .par_even_i(pev),
    .rd_i(rd), .err_reset_i(err_rst), .data_o(data), .avail_o(avail),
    .par_err_o(par_err), .ovr_err_o(ovr_err), .frm_err_o(frm_err), .break_o(brk)
  );

  task automatic chk(input bit ok, input logic [23:0] tag, input int act, input int expv);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, expv);
    end
  endtask

  function automatic int len_of(input logic [1:0] c);
    case (c)
      2'd0: return 5;
      2'd1: return 7;
      2'd2: return 6;
      default: return 8;
    endcase
  endfunction

  function automatic int per_of(input logic [1:0] c);
    case (c)
      2'd0: return 1;
      2'd1: return 16;
      2'd2: return 32;
      default: return 64;
    endcase
  endfunction

  task automatic hold(input logic v, input int n);
    rx = v;
    repeat (n) @(negedge clk);
  endtask

  task automatic send_frame(input logic [7:0] d, input bit bad_par, input bit stop_v,
                            input logic [23:0] tag, input bit expect_it);
    int n;
    int p;
    logic [7:0] m;
    logic pb;
    n  = len_of(len);
    p  = per_of(mode);
    m  = d & (8'hFF >> (8 - n));
    pb = ^m;
    if (!pev) pb = ~pb;
    if (bad_par) pb = ~pb;
    if (expect_it) q.push_back({m, ~stop_v, tag});
    hold(1'b0, p);
    for (int i = 0; i < n; i++) hold(m[i], p);
    if (pe) hold(pb, p);
    hold(stop_v, p);
    hold(1'b1, 2 * p + 6);
  endtask

  task automatic drain(input logic [23:0] tag);
    for (int i = 0; i < 3000 && q.size() != 0; i++) @(negedge clk);
    chk(q.size() == 0, tag, q.size(), 0);
  endtask

  task automatic pulse_err_rst;
    err_rst = 1'b1;
    @(negedge clk);
    err_rst = 1'b0;
    @(negedge clk);
  endtask

  // scoreboard monitor
  initial begin
    exp_t e;
    forever begin
      @(negedge clk);
      if (mon_en && avail) begin
        if (q.size() == 0) begin
          chk(1'b0, "R6 ", data, 0);
        end else begin
          e = q.pop_front();
          chk(data == e.d, e.tag, data, e.d);
          chk(frm_err == e.frm, e.tag, frm_err, e.frm);
        end
        mon_rd = 1'b1;
        @(negedge clk);
        mon_rd = 1'b0;
      end
    end
  end

  initial begin
    #(200000 * 10);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog act=hung exp=done");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(!avail && !brk, "R1 ", {avail, brk}, 0);
    chk(!par_err && !ovr_err && !frm_err, "R1 ", {par_err, ovr_err, frm_err}, 0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk(!avail && !par_err && !ovr_err, "R1 ", {avail, par_err, ovr_err}, 0);

    // R2/R3: every length code in every clock mode
    for (int mm = 0; mm < 4; mm++) begin
      for (int ll = 0; ll < 4; ll++) begin
        mode = 2'(mm);
        len  = 2'(ll);
        send_frame(8'hB5 ^ 8'(mm * 37 + ll * 11), 1'b0, 1'b1, (mm == 0) ? "R2 " : "R3 ", 1'b1);
      end
    end
    drain("R2 ");

    // R4 parity, R10 clear
    mode = 2'd1; len = 2'd3; pe = 1'b1;
    pev = 1'b1; send_frame(8'h3C, 1'b0, 1'b1, "R4 ", 1'b1);
    pev = 1'b0; send_frame(8'h81, 1'b0, 1'b1, "R4 ", 1'b1);
    drain("R4 ");
    chk(!par_err, "R4 ", par_err, 0);
    pev = 1'b1; send_frame(8'h07, 1'b1, 1'b1, "R4 ", 1'b1);
    drain("R4 ");
    repeat (4) @(negedge clk);
    chk(par_err, "R4 ", par_err, 1);
    pulse_err_rst;
    chk(!par_err, "R10", par_err, 0);
    pe = 1'b0;

    // R5 framing error on nonzero data, no break
    send_frame(8'h5A, 1'b0, 1'b0, "R5 ", 1'b1);
    drain("R5 ");
    chk(!brk, "R8 ", brk, 0);

    // R3 glitch shorter than half a bit
    hold(1'b0, 4);
    hold(1'b1, 60);
    chk(!avail, "R3 ", avail, 0);
    send_frame(8'hC3, 1'b0, 1'b1, "R3 ", 1'b1);
    drain("R3 ");

    // R8 break: whole frame low, then held low
    q.push_back({8'h00, 1'b1, "R8 "});
    hold(1'b0, 16 * 14);
    chk(brk, "R8 ", brk, 1);
    drain("R8 ");
    chk(!avail, "R8 ", avail, 0);
    hold(1'b1, 8);
    chk(!brk, "R8 ", brk, 0);
    hold(1'b1, 32);

    // R6/R7 overrun with read on empty first
    mon_en = 1'b0;
    tst_rd = 1'b1; @(negedge clk); tst_rd = 1'b0; @(negedge clk);
    chk(!avail, "R6 ", avail, 0);
    send_frame(8'h11, 1'b0, 1'b1, "R6 ", 1'b1);
    send_frame(8'h22, 1'b0, 1'b1, "R6 ", 1'b1);
    send_frame(8'h33, 1'b0, 1'b1, "R7 ", 1'b0);
    chk(!ovr_err, "R7 ", ovr_err, 0);
    send_frame(8'h44, 1'b0, 1'b1, "R7 ", 1'b1);
    chk(ovr_err, "R7 ", ovr_err, 1);
    chk(avail && data == 8'h11, "R7 ", data, 8'h11);
    mon_en = 1'b1;
    drain("R7 ");
    repeat (4) @(negedge clk);
    chk(ovr_err, "R10", ovr_err, 1);
    pulse_err_rst;
    chk(!ovr_err, "R10", ovr_err, 0);

    // R9 disabled receiver keeps stored data, ignores line
    mon_en = 1'b0;
    send_frame(8'h66, 1'b0, 1'b1, "R9 ", 1'b1);
    rx_en = 1'b0;
    send_frame(8'h77, 1'b0, 1'b1, "R9 ", 1'b0);
    chk(avail && data == 8'h66, "R9 ", data, 8'h66);
    rx_en = 1'b1;
    repeat (4) @(negedge clk);
    mon_en = 1'b1;
    drain("R9 ");
    repeat (8) @(negedge clk);
    chk(!avail, "R9 ", avail, 0);

    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule